// File: doc/BRIEF.md
# Pulse-Width Slot Encoder

This block serialises a parallel word onto one idle-high wire. Time on the wire is divided into slots by an external tick that pulses once per slot period, nominally one microsecond. Every data bit takes four consecutive slots:

- the first slot is always low;
- the middle two slots carry the bit value;
- the last slot is always high.

A zero and a one therefore differ only in the middle of the bit. Every bit starts with a falling edge, which lets a receiver resynchronise on each bit.

A client presents the word, together with the number of bits to send, and pulses a load strobe while the block is idle. The block reports busy from the accepted load until the frame ends. It waits for the next tick, then drives the frame, starting with bit index 0. When the high slot of the final bit ends, it releases the wire and pulses done for one clock. The output-enable lets the serial output share a wire with other drivers. While the enable is low, the output rests at the idle-high level.

Top module: `pw_slot_encoder`

## Requirements
- R1: Out of reset, and whenever busy is low, line_oe is 0, line_out is 1 and done is 0.
- R2: A load pulse with a non-zero bit count while idle raises busy on the next clock. The wire stays released and high until the first tick after the load.
- R3: The first slot of every bit drives line_out low.
- R4: The second and third slots of every bit drive line_out to that bit's value (1 high, 0 low).
- R5: The fourth slot of every bit drives line_out high.
- R6: Bits leave in ascending index order, starting with word_in[0].
- R7: The number of bits sent equals bit_count. A count above MAX_BITS (default 86) is treated as MAX_BITS.
- R8: On the tick that ends the fourth slot of the final bit, the block does all of the following on the next clock: busy falls, line_oe falls, line_out is high, and done is 1 for exactly one clock.
- R9: A load pulse while busy is ignored. The frame in progress is unchanged, and no second frame follows it.
- R10: A load pulse with bit_count equal to 0 is ignored, and busy stays low.
- R11: line_oe is high only while busy is high, from the first tick after the load until the frame ends.
- R12: line_out and line_oe change only on the clock after a tick, or on the load itself, which leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse marking each slot boundary |
| load | input | 1 | Start strobe, accepted only while idle |
| word_in | input | MAX_BITS | Word to send, bit 0 first |
| bit_count | input | CNT_W | Number of bits to send |
| line_out | output | 1 | Serial level, high when idle |
| line_oe | output | 1 | Drive enable for the shared wire |
| busy | output | 1 | A frame is armed or in progress |
| done | output | 1 | One-clock pulse after the final slot |

## Verification
The properties assume the following about the inputs:

- tick is a single-clock pulse, spaced widely enough that each slot lasts many clocks.
- word_in and bit_count are only meaningful in the cycle in which load is high.

The bench produces tick from a free-running divider that pulses every eighth clock. It drives load, word_in and bit_count away from the active edge, for exactly one cycle each time. The single load issued inside a frame lands several slots in, after the transmission has fully started.

// File: rtl/pw_slot_pkg.sv
package pw_slot_pkg;
    localparam int SLOTS_PER_BIT = 4;
    localparam int SLOT_W        = 2;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_ARM  = 2'd1,
        MODE_SEND = 2'd2
    } tx_mode_e;
endpackage

// File: rtl/pw_slot_level.sv
module pw_slot_level
    import pw_slot_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic              bit_val,
    output logic              level
);
    // Slot 0 opens every bit low, slot 3 closes it high,
    // the middle pair carries the data value.
    always_comb begin
        unique case (slot)
            SLOT_W'(0):                 level = 1'b0;
            SLOT_W'(SLOTS_PER_BIT - 1): level = 1'b1;
            default:                    level = bit_val;
        endcase
    end
endmodule

// File: rtl/pw_count_clamp.sv
module pw_count_clamp #(
    parameter int MAX_BITS = 86,
    parameter int CNT_W    = $clog2(MAX_BITS + 1),
    parameter int IDX_W    = $clog2(MAX_BITS)
) (
    input  logic [CNT_W-1:0] count,
    output logic             nonzero,
    output logic [IDX_W-1:0] last_idx
);
    logic [CNT_W-1:0] eff_count;

    always_comb begin
        nonzero   = (count != '0);
        eff_count = (count > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : count;
        last_idx  = nonzero ? IDX_W'(eff_count - CNT_W'(1)) : '0;
    end
endmodule

// File: rtl/pw_slot_encoder.sv
module pw_slot_encoder
    import pw_slot_pkg::*;
#(
    parameter int MAX_BITS = 86,
    parameter int CNT_W    = $clog2(MAX_BITS + 1),
    parameter int IDX_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                load,
    input  logic [MAX_BITS-1:0] word_in,
    input  logic [CNT_W-1:0]    bit_count,
    output logic                line_out,
    output logic                line_oe,
    output logic                busy,
    output logic                done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_BIT - 1);

    typedef struct packed {
        tx_mode_e            mode;
        logic [SLOT_W-1:0]   slot;
        logic [IDX_W-1:0]    bit_idx;
        logic [IDX_W-1:0]    last_idx;
        logic [MAX_BITS-1:0] shreg;
        logic                line;
        logic                oe;
        logic                done;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic              cnt_nonzero;
    logic [IDX_W-1:0]  cnt_last_idx;
    logic [SLOT_W-1:0] slot_nx;
    logic              bit_nx;
    logic              level_nx;
    logic              bit_wrap;

    pw_count_clamp #(
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_clamp (
        .count    (bit_count),
        .nonzero  (cnt_nonzero),
        .last_idx (cnt_last_idx)
    );

    // Slot and data bit that the next tick moves into.
    always_comb begin
        bit_wrap = (st_q.mode == MODE_SEND) && (st_q.slot == LAST_SLOT);
        if (st_q.mode == MODE_SEND) begin
            slot_nx = st_q.slot + SLOT_W'(1);
        end else begin
            slot_nx = '0;
        end
        bit_nx = bit_wrap ? st_q.shreg[1] : st_q.shreg[0];
    end

    pw_slot_level u_level (
        .slot    (slot_nx),
        .bit_val (bit_nx),
        .level   (level_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (load && cnt_nonzero) begin
                    st_d.mode     = MODE_ARM;
                    st_d.shreg    = word_in;
                    st_d.last_idx = cnt_last_idx;
                    st_d.bit_idx  = '0;
                    st_d.slot     = '0;
                end
            end
            MODE_ARM: begin
                if (tick) begin
                    st_d.mode = MODE_SEND;
                    st_d.slot = slot_nx;
                    st_d.oe   = 1'b1;
                    st_d.line = level_nx;
                end
            end
            MODE_SEND: begin
                if (tick) begin
                    if (bit_wrap && (st_q.bit_idx == st_q.last_idx)) begin
                        st_d.mode = MODE_IDLE;
                        st_d.oe   = 1'b0;
                        st_d.line = 1'b1;
                        st_d.done = 1'b1;
                        st_d.slot = '0;
                    end else begin
                        st_d.slot = slot_nx;
                        st_d.line = level_nx;
                        if (bit_wrap) begin
                            st_d.bit_idx = st_q.bit_idx + IDX_W'(1);
                            st_d.shreg   = st_q.shreg >> 1;
                        end
                    end
                end
            end
            default: begin
                st_d.mode = MODE_IDLE;
                st_d.oe   = 1'b0;
                st_d.line = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_IDLE;
            st_q.line     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_out = st_q.line;
    assign line_oe  = st_q.oe;
    assign busy     = (st_q.mode != MODE_IDLE);
    assign done     = st_q.done;
endmodule

// File: rtl/pw_slot_encoder_chk.sv
module pw_slot_encoder_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] bit_count,
    input logic             line_out,
    input logic             line_oe,
    input logic             busy,
    input logic             done
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_oe && line_out)); // R1

    AST_ZERO_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load && bit_count == '0) |=> !busy); // R10

    AST_FIRST_SLOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !line_oe && line_out)); // R8

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> busy); // R11

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(line_out) && $stable(line_oe))); // R12
endmodule

bind pw_slot_encoder pw_slot_encoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .bit_count (bit_count),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .busy      (busy),
    .done      (done)
);

// File: tb/pw_slot_encoder_bench.sv
`timescale 1ns/1ps
module pw_slot_encoder_bench;
    localparam int MAXB = 86;
    localparam int CW   = $clog2(MAXB + 1);
    localparam int RECN = 4 * MAXB + 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic            load = 1'b0;
    logic [MAXB-1:0] word_in = '0;
    logic [CW-1:0]   bit_count = '0;
    logic            line_out, line_oe, busy, done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pw_slot_encoder #(.MAX_BITS(MAXB)) u_pw_slot_encoder (
        .clk (clk), .rst_n (rst_n), .tick (tick), .load (load),
        .word_in (word_in), .bit_count (bit_count),
        .line_out (line_out), .line_oe (line_oe), .busy (busy), .done (done)
    );

    // Slot tick: one clock high every eighth clock.
    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = tcnt + 1;
            tick = (tcnt % 8 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !line_oe && line_out && !done, "R1", "in reset idle state",
            {busy, line_oe, line_out, done}, 4'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !line_oe && line_out && !done, "R1", "after reset idle state",
            {busy, line_oe, line_out, done}, 4'b0010);
    endtask

    task automatic t_frame(input logic [MAXB-1:0] w, input int cnt,
                           input bit inject, input string tag);
        logic rec [0:RECN-1];
        int   exp_n = (cnt > MAXB) ? MAXB : cnt;
        int   nrec = 0;
        int   guard = 0;
        bit   seen_done = 0;
        bit   injected = 0;
        int   e3 = 0, e4 = 0, e5 = 0;
        $display("frame %s", tag);
        @(negedge clk);
        load = 1'b1; word_in = w; bit_count = CW'(cnt);
        @(negedge clk);
        load = 1'b0;
        chk(busy && !line_oe && line_out, "R2", "armed before first tick",
            {busy, line_oe, line_out}, 3'b101);
        while (!seen_done && guard < 20000) begin
            @(posedge clk); #1;
            guard++;
            if (load) load = 1'b0;
            if (tick && line_oe) begin
                if (nrec < RECN) rec[nrec] = line_out;
                nrec++;
            end
            if (done) seen_done = 1;
            if (inject && !injected && nrec == 6) begin
                load = 1'b1; word_in = ~w; bit_count = CW'(3);
                injected = 1;
            end
        end
        load = 1'b0;
        chk(seen_done, "R8", "done seen", seen_done, 1);
        chk(nrec == 4 * exp_n, "R7", "slot count", nrec, 4 * exp_n);
        for (int k = 0; k < nrec && k < RECN && k < 4 * exp_n; k++) begin
            case (k % 4)
                0: if (rec[k] !== 1'b0) e3++;
                3: if (rec[k] !== 1'b1) e5++;
                default: if (rec[k] !== w[k / 4]) e4++;
            endcase
        end
        chk(e3 == 0, "R3", "low first slots", e3, 0);
        chk(e4 == 0, "R4 R6", "value slots in index order", e4, 0);
        chk(e5 == 0, "R5", "high last slots", e5, 0);
        chk(!busy && !line_oe && line_out, "R8", "released at done",
            {busy, line_oe, line_out}, 3'b001);
        @(posedge clk); #1;
        chk(!done, "R8", "done width", done, 0);
        if (inject) begin
            repeat (40) @(posedge clk);
            #1;
            chk(!busy && !line_oe, "R9", "no frame after ignored load",
                {busy, line_oe}, 0);
        end
    endtask

    task automatic t_zero_count();
        int hits = 0;
        @(negedge clk);
        load = 1'b1; word_in = '1; bit_count = '0;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy || line_oe) hits++;
        end
        chk(hits == 0, "R10", "zero count ignored", hits, 0);
    endtask

    initial begin
        t_reset();
        t_frame({{(MAXB-5){1'b0}}, 5'b00000}, 5, 0, "zeros");
        t_frame({{(MAXB-5){1'b0}}, 5'b11111}, 5, 0, "ones");
        t_frame({{(MAXB-8){1'b0}}, 8'b0010_1101}, 8, 0, "mixed");
        t_frame({{(MAXB-1){1'b0}}, 1'b1}, 1, 0, "single bit");
        t_frame({22'h2A_5C3F, 64'hF0E1_D2C3_B4A5_9687}, 86, 0, "full word");
        t_frame({22'h15_0F0F, 64'h0123_4567_89AB_CDEF}, 100, 0, "clamped count");
        t_frame({{(MAXB-12){1'b0}}, 12'b1100_1010_0110}, 12, 1, "load while busy");
        t_zero_count();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule